// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification

This block decides which interrupt a 16550-style serial port reports to its host, and it drives the port's interrupt line. It has five event sources: receive line errors and breaks, received data, the character timeout of a receive FIFO, an empty transmit holder, and modem signal changes. Each source has its own latch and its own clear rule. A fixed priority encoder picks the most urgent enabled source. The result is packed into an identification byte whose pending bit is active low.

The host writes a 4-bit enable register through the block. It also pulses read and write strobes for the line status, modem status, receive buffer, transmit holder and identification registers, so the block can clear sources. In FIFO mode, the receive-data source comes from a comparison of the FIFO fill level with a trigger level. The FIFO storage, the shifters and the bus decoding are all outside this block.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register is 0. A write stores data bits 3:0: bit 3 modem, bit 2 line status, bit 1 transmit empty, bit 0 receive data. Bits 7:4 always read 0.
- R2: The identification byte is laid out as bit 7 = FIFO mode, bits 6:4 = 0, bits 3:1 = source code, bit 0 = 0 when an interrupt is pending. With nothing pending it reads 0x01 (0x81 in FIFO mode).
- R3: Source codes in priority order are: line status 011, character timeout 110, received data 010, transmit empty 001, modem 000. The highest active source is reported.
- R4: `irq` is high exactly when some source is both latched and enabled. A source that occurs while disabled is held, and it appears when it is enabled later.
- R5: A line event latches the line status source, and a line status read clears it. An event in the same cycle as the read leaves the source latched.
- R6: With FIFO mode off, a received character pulse latches the received data source, and a receive buffer read clears it.
- R7: With FIFO mode on, the received data source is active while fill level >= trigger level. Receive buffer reads have no effect on it.
- R8: The character timeout latches only in FIFO mode and is cleared by a receive buffer read. With FIFO mode off, bit 3 of the identification byte is always 0.
- R9: The transmit empty source latches on a rising edge of the holder-empty input, including the first cycle after reset. A holder write clears it. An identification read clears it only while it is the reported source.
- R10: A modem change latches the modem source, and a modem status read clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wdata | input | 8 | Host write data for the enable register |
| ier_wr | input | 1 | Enable register write strobe |
| thr_wr | input | 1 | Transmit holder write strobe |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| fifo_en | input | 1 | FIFO mode active |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| trig_level | input | LVL_W | Receive FIFO trigger level |
| line_evt | input | 1 | Line error or break event pulse |
| rx_char | input | 1 | Character received pulse (non-FIFO mode) |
| rx_tmo | input | 1 | Character timeout pulse |
| thr_empty | input | 1 | Transmit holder empty level |
| modem_evt | input | 1 | Modem signal change pulse |
| ier_q | output | 8 | Enable register read value |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Two of the block's functions can fall in the same cycle: a new line event, and the line status read that clears the earlier one. The bench latches a line error, then drives the event and the read strobe in one cycle. It expects code 011 with the pending bit low afterwards. A following read with no event must bring the byte back to 0x01. A second overlap is an identification read that arrives while a higher source masks the transmit empty source. The bench checks that transmit empty survives that read and is cleared only by a later read that reports it.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int SRC_N  = 5;
   // source index doubles as priority rank (0 = most urgent)
   localparam int S_LINE = 0;
   localparam int S_TMO  = 1;
   localparam int S_RXD  = 2;
   localparam int S_TXE  = 3;
   localparam int S_MDM  = 4;

   typedef enum logic [2:0] {
      ID_MODEM = 3'b000,
      ID_TXE   = 3'b001,
      ID_RXD   = 3'b010,
      ID_LINE  = 3'b011,
      ID_TMO   = 3'b110
   } irq_id_e;

   function automatic irq_id_e id_of(input int idx);
      case (idx)
         S_LINE:  return ID_LINE;
         S_TMO:   return ID_TMO;
         S_RXD:   return ID_RXD;
         S_TXE:   return ID_TXE;
         default: return ID_MODEM;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_flag.sv
// Sticky source latch; SET_WINS chooses which strobe dominates a collision.
module uart_irq_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);

   generate
      if (SET_WINS) begin : g_set_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_o <= 1'b0;
            else if (set_i) flag_o <= 1'b1;
            else if (clr_i) flag_o <= 1'b0;
         end
      end else begin : g_clr_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flag_o <= 1'b0;
            else if (clr_i) flag_o <= 1'b0;
            else if (set_i) flag_o <= 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority grant: lowest index wins.
module uart_irq_prio #(
   parameter int N = 5
) (
   input  logic [N-1:0] req_i,
   output logic [N-1:0] gnt_o,
   output logic         any_o
);

   generate
      if (N < 2) begin : g_bad_n
         $error("uart_irq_prio: N must be at least 2");
      end
   endgenerate

   always_comb begin
      logic taken;
      taken = 1'b0;
      gnt_o = '0;
      for (int i = 0; i < N; i++) begin
         if (req_i[i] && !taken) begin
            gnt_o[i] = 1'b1;
            taken    = 1'b1;
         end
      end
      any_o = taken;
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       wdata,
   input  logic             ier_wr,
   input  logic             thr_wr,
   input  logic             iir_rd,
   input  logic             lsr_rd,
   input  logic             rbr_rd,
   input  logic             msr_rd,
   input  logic             fifo_en,
   input  logic [LVL_W-1:0] fifo_level,
   input  logic [LVL_W-1:0] trig_level,
   input  logic             line_evt,
   input  logic             rx_char,
   input  logic             rx_tmo,
   input  logic             thr_empty,
   input  logic             modem_evt,
   output logic [7:0]       ier_q,
   output logic [7:0]       iir_q,
   output logic             irq
);

   localparam int EN_W = 4;
   localparam int EN_RXD = 0;
   localparam int EN_TXE = 1;
   localparam int EN_LINE = 2;
   localparam int EN_MDM = 3;
   // transmit empty is the only source whose clear beats its set
   localparam logic [SRC_N-1:0] SET_WINS_MASK = ~(SRC_N'(1) << S_TXE);

   generate
      if (LVL_W < 1 || LVL_W > 16) begin : g_bad_lvl
         $error("uart_irq_ident: LVL_W out of range 1..16");
      end
   endgenerate

   logic [EN_W-1:0]  en_q;
   logic             thr_empty_d;
   logic [SRC_N-1:0] set_v, clr_v, flag_v, req_v, gnt_v;
   logic             any_pend;
   irq_id_e          code;

   // enable register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      en_q <= '0;
      else if (ier_wr) en_q <= wdata[EN_W-1:0];
   end
   assign ier_q = {{(8-EN_W){1'b0}}, en_q};

   // holder-empty edge detector (starts low so an empty holder arms at reset exit)
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_empty_d <= 1'b0;
      else        thr_empty_d <= thr_empty;
   end

   // per-source set and clear rules
   always_comb begin
      set_v = '0;
      clr_v = '0;
      set_v[S_LINE] = line_evt;
      clr_v[S_LINE] = lsr_rd;
      set_v[S_TMO]  = rx_tmo & fifo_en;
      clr_v[S_TMO]  = rbr_rd;
      set_v[S_RXD]  = rx_char;
      clr_v[S_RXD]  = rbr_rd;
      set_v[S_TXE]  = thr_empty & ~thr_empty_d;
      clr_v[S_TXE]  = thr_wr | (iir_rd & gnt_v[S_TXE]);
      set_v[S_MDM]  = modem_evt;
      clr_v[S_MDM]  = msr_rd;
   end

   genvar gi;
   generate
      for (gi = 0; gi < SRC_N; gi++) begin : g_src
         uart_irq_flag #(.SET_WINS(SET_WINS_MASK[gi])) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v[gi]),
            .clr_i  (clr_v[gi]),
            .flag_o (flag_v[gi])
         );
      end
   endgenerate

   // qualified requests
   always_comb begin
      req_v         = '0;
      req_v[S_LINE] = flag_v[S_LINE] & en_q[EN_LINE];
      req_v[S_TMO]  = flag_v[S_TMO] & fifo_en & en_q[EN_RXD];
      req_v[S_RXD]  = en_q[EN_RXD] &
                      (fifo_en ? (fifo_level >= trig_level) : flag_v[S_RXD]);
      req_v[S_TXE]  = flag_v[S_TXE] & en_q[EN_TXE];
      req_v[S_MDM]  = flag_v[S_MDM] & en_q[EN_MDM];
   end

   uart_irq_prio #(.N(SRC_N)) u_prio (
      .req_i (req_v),
      .gnt_o (gnt_v),
      .any_o (any_pend)
   );

   always_comb begin
      code = ID_MODEM;
      for (int i = 0; i < SRC_N; i++) begin
         if (gnt_v[i]) code = id_of(i);
      end
   end

   assign iir_q = {fifo_en, 3'b000, code, ~any_pend};
   assign irq   = any_pend;

   // assertions
   a_r3_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt_v));

   a_r5_line_reported: assert property (@(posedge clk) disable iff (!rst_n)
      (line_evt && en_q[EN_LINE] && !ier_wr) |=> (iir_q[3:0] == 4'b0110));

   a_r5_line_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !line_evt) |=> !flag_v[S_LINE]);

   a_r8_iid2_off: assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |-> !iir_q[3]);

   a_r9_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
      thr_wr |=> !flag_v[S_TXE]);

   a_r10_modem_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (msr_rd && !modem_evt) |=> !flag_v[S_MDM]);

   a_r4_irq_vs_pending: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !iir_q[0]);

endmodule

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;

   localparam int LVL_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] wdata = '0;
   logic ier_wr = 0, thr_wr = 0, iir_rd = 0, lsr_rd = 0, rbr_rd = 0, msr_rd = 0;
   logic fifo_en = 0;
   logic [LVL_W-1:0] fifo_level = '0, trig_level = '0;
   logic line_evt = 0, rx_char = 0, rx_tmo = 0, thr_empty = 1, modem_evt = 0;
   logic [7:0] ier_q, iir_q;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   uart_irq_ident #(.LVL_W(LVL_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wdata(wdata), .ier_wr(ier_wr), .thr_wr(thr_wr),
      .iir_rd(iir_rd), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd), .msr_rd(msr_rd),
      .fifo_en(fifo_en), .fifo_level(fifo_level), .trig_level(trig_level),
      .line_evt(line_evt), .rx_char(rx_char), .rx_tmo(rx_tmo),
      .thr_empty(thr_empty), .modem_evt(modem_evt),
      .ier_q(ier_q), .iir_q(iir_q), .irq(irq)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_strobes();
      ier_wr = 0; thr_wr = 0; iir_rd = 0; lsr_rd = 0; rbr_rd = 0; msr_rd = 0;
      line_evt = 0; rx_char = 0; rx_tmo = 0; modem_evt = 0;
   endtask

   // every strobe is driven for one cycle, outputs sampled at the following negedge
   task automatic write_ier(input logic [7:0] v);
      wdata = v; ier_wr = 1; tick(); clear_strobes();
   endtask

   task automatic t_reset();
      chk(ier_q, 8'h00, "R1 reset enable");
      chk(iir_q, 8'h01, "R2 reset ident");
      chk({7'b0, irq}, 8'h00, "R4 reset irq");
   endtask

   task automatic t_enable_reg();
      write_ier(8'hFF);
      chk(ier_q, 8'h0F, "R1 upper bits zero");
      write_ier(8'h00);
      chk(ier_q, 8'h00, "R1 cleared");
   endtask

   task automatic t_tx_empty();
      // flag armed after reset while disabled
      write_ier(8'h02);
      chk(iir_q, 8'h02, "R4 held source appears");
      chk({7'b0, irq}, 8'h01, "R4 irq up");
      iir_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R9 ident read clears");
      chk({7'b0, irq}, 8'h00, "R4 irq down");
      thr_empty = 0; tick(); thr_empty = 1; tick();
      chk(iir_q, 8'h02, "R9 rearm on empty edge");
      thr_wr = 1; thr_empty = 0; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R9 holder write clears");
      thr_empty = 1; tick();
   endtask

   task automatic t_priority();
      write_ier(8'h0F);
      chk(iir_q, 8'h02, "R9 empty edge while enabled");
      modem_evt = 1; tick(); clear_strobes();
      chk(iir_q, 8'h02, "R3 empty above modem");
      rx_char = 1; tick(); clear_strobes();
      chk(iir_q, 8'h04, "R3 rx data over empty");
      line_evt = 1; tick(); clear_strobes();
      chk(iir_q, 8'h06, "R3 line highest");
      iir_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h06, "R9 ident read with other source");
      lsr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h04, "R5 line read clears");
      rbr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h02, "R6 rbr read clears; R9 empty survived");
      iir_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h00, "R9 cleared when reported; R10 modem visible");
      msr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R10 modem read clears");
   endtask

   task automatic t_line_race();
      line_evt = 1; tick(); clear_strobes();
      line_evt = 1; lsr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h06, "R5 event beats read");
      lsr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R5 plain read clears");
   endtask

   task automatic t_fifo();
      fifo_en = 1; trig_level = 5'd4; fifo_level = 5'd3; tick();
      chk(iir_q, 8'h81, "R2 fifo flag idle");
      chk({7'b0, irq}, 8'h00, "R7 below trigger");
      fifo_level = 5'd4; tick();
      chk(iir_q, 8'h84, "R7 at trigger");
      rbr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h84, "R7 read no effect");
      fifo_level = 5'd3; tick();
      chk(iir_q, 8'h81, "R7 drops below trigger");
      rx_tmo = 1; tick(); clear_strobes();
      chk(iir_q, 8'h8C, "R8 timeout code");
      fifo_level = 5'd4; tick();
      chk(iir_q, 8'h8C, "R3 timeout above rx data");
      rbr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h84, "R8 rbr read clears timeout");
      fifo_level = 5'd2; tick();
      chk(iir_q, 8'h81, "R7 idle again");
      fifo_en = 0; tick();
   endtask

   task automatic t_no_fifo_timeout();
      rx_tmo = 1; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R8 timeout ignored without fifo");
      fifo_en = 1; fifo_level = 5'd0; tick();
      chk(iir_q, 8'h81, "R8 nothing latched earlier");
      fifo_en = 0; tick();
   endtask

   task automatic t_disabled();
      write_ier(8'h07);
      modem_evt = 1; tick(); clear_strobes();
      chk({7'b0, irq}, 8'h00, "R4 disabled modem no irq");
      chk(iir_q, 8'h01, "R4 disabled modem hidden");
      write_ier(8'h0F);
      chk(iir_q, 8'h00, "R4 modem after enable");
      chk({7'b0, irq}, 8'h01, "R4 irq after enable");
      msr_rd = 1; tick(); clear_strobes();
      chk(iir_q, 8'h01, "R10 cleared");
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (3) tick();
      rst_n = 1;
      tick();
      t_reset();
      tick();
      t_enable_reg();
      t_tx_empty();
      t_priority();
      t_line_race();
      t_fifo();
      t_no_fifo_timeout();
      t_disabled();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

endmodule